// File: doc/BRIEF.md
# Four-Lane Window Multiplier

This block scales four synchronized complex sample streams by a real window coefficient before they enter a transform engine. On every clock an input beat carries one complex sample per lane and one shared position index within the transform block. Every lane uses the same coefficient for that position. The real and imaginary parts of each lane go through their own multiplier, so the block has eight real multipliers. Each product is rounded back to the sample width and saturates if it overflows.

The coefficients are held in a table that is separate from any twiddle storage. After reset the table holds a Hann window. A small write port stages new coefficients, and the staged set takes effect only at the next block boundary. A running block therefore never mixes two windows. A per-beat bypass control passes samples through unchanged with the same latency as window mode, so downstream timing does not depend on the mode.

Top module: `win4_apply`

## Requirements
- R1: While `rst_ni` is low and after it is released, before any valid beat has come out, `valid_o` is 0 and `re_o`/`im_o` are all zero.
- R2: In window mode each output component equals round(x * w[idx] / 2^(COEF_W-1)). The coefficient w is unsigned with COEF_W-1 fraction bits, so 1.0 is 0x8000 for COEF_W=16. After reset, w[n] = floor(2^(COEF_W-1) * (0.5 - 0.5*cos(2*pi*n/NPTS)) + 0.5).
- R3: In bypass mode each output component equals the matching input component.
- R4: The latency is exactly 3 clock cycles in both modes. `valid_o` repeats `valid_i` 3 cycles later, and a beat with `valid_i` low produces no valid output.
- R5: A table write (`wr_en_i`, `wr_addr_i`, `wr_data_i`) updates a staging copy. A block boundary is a beat with `valid_i`=1 and `idx_i`=0. At each boundary the staging copy becomes the active table, and the boundary beat itself uses the new contents. A write in the same cycle as a boundary takes effect at the following boundary.
- R6: A result beyond the signed DATA_W range saturates: to 2^(DATA_W-1)-1 on the high side and to -2^(DATA_W-1) on the low side.
- R7: Rounding adds half an LSB and then shifts right arithmetically, so exact halves round toward plus infinity. With w=0.5: x=1 gives 1, x=-1 gives 0, x=3 gives 2, x=-3 gives -1.
- R8: Lane k sits in bits [k*DATA_W +: DATA_W] of `re_*` and `im_*`. All four lanes and both components are scaled independently by the same coefficient.
- R9: `bypass_i` is sampled with each beat, so window and bypass beats may alternate freely with no gap.
- R10: A beat with `valid_i` low never commits staged writes, even when `idx_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input beat valid |
| idx_i | input | IDX_W | Position of the beat within the transform block |
| bypass_i | input | 1 | 1: pass the beat through unscaled |
| re_i | input | LANES*DATA_W | Real parts, signed, lane k at [k*DATA_W +: DATA_W] |
| im_i | input | LANES*DATA_W | Imaginary parts, same packing |
| wr_en_i | input | 1 | Coefficient staging write enable |
| wr_addr_i | input | IDX_W | Coefficient write address |
| wr_data_i | input | COEF_W | Coefficient value, unsigned, COEF_W-1 fraction bits |
| valid_o | output | 1 | Output beat valid |
| re_o | output | LANES*DATA_W | Scaled real parts |
| im_o | output | LANES*DATA_W | Scaled imaginary parts |

## Verification
Random full-scale data runs through a whole block with the default table. Every lane and component carries different values, so a lane swap, a component swap or a wrong table entry shows up as a mismatch. The same data is then repeated in bypass, and again with bypass toggling and with idle gaps, which separates a mode error from a latency error. Coefficients written in the middle of a block, writes next to an idle beat at index 0, and writes on the boundary beat itself show whether commits happen at the right time. Saturation and half-LSB rounding are checked separately, with table entries of nearly 2.0 and exactly 0.5 and hand-picked extreme and odd inputs.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam real PI_C = 3.14159265358979323846;

  // Hann value scaled to unsigned fixed point with cw-1 fraction bits
  function automatic int hann_q(input int n, input int npts, input int cw);
    real ph;
    real w;
    ph = 2.0 * PI_C * real'(n) / real'(npts);
    w  = 0.5 - 0.5 * $cos(ph);
    return $rtoi(w * (2.0 ** (cw - 1)) + 0.5);
  endfunction
endpackage

// File: rtl/win_coef_table.sv
module win_coef_table
  import win_pkg::*;
#(
  parameter int NPTS   = 64,
  parameter int COEF_W = 16,
  localparam int IDX_W = $clog2(NPTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [COEF_W-1:0] coef_o
);
  logic [NPTS-1:0][COEF_W-1:0] shadow_q, active_q;
  logic [COEF_W-1:0] coef_q;
  logic commit;

  assign commit = rd_en_i && (rd_idx_i == '0);

  for (genvar i = 0; i < NPTS; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[i] <= COEF_W'(hann_q(i, NPTS, COEF_W));
        active_q[i] <= COEF_W'(hann_q(i, NPTS, COEF_W));
      end else begin
        if (wr_en_i && (wr_addr_i == IDX_W'(i))) shadow_q[i] <= wr_data_i;
        if (commit) active_q[i] <= shadow_q[i];
      end
    end
  end

  // boundary beat reads the contents it is about to commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_q <= '0;
    else if (rd_en_i) coef_q <= commit ? shadow_q[rd_idx_i] : active_q[rd_idx_i];
  end

  assign coef_o = coef_q;

  assert_hold_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(active_q));
  assert_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (active_q == $past(shadow_q)));
  assert_idle_no_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && rd_idx_i == '0) |=> $stable(active_q));
endmodule

// File: rtl/win_scale.sv
module win_scale #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic                     byp_i,
  input  logic        [COEF_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int FRAC = COEF_W - 1;
  localparam int PW   = DATA_W + COEF_W + 1;
  localparam logic signed [PW:0] HALF = (PW+1)'(1) << (FRAC - 1);
  localparam logic signed [PW:0] MAXV = (PW+1)'((64'd1 << (DATA_W - 1)) - 64'd1);
  localparam logic signed [PW:0] MINV = ~MAXV;
  localparam logic [COEF_W-1:0] ONE   = COEF_W'(1) << FRAC;

  logic signed [PW-1:0]     prod_q;
  logic signed [DATA_W-1:0] x_q, y_q, sat_val;
  logic                     byp_q, vld_q;
  logic signed [PW:0]       rnd, shr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      x_q    <= '0;
      byp_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        prod_q <= x_i * $signed({1'b0, coef_i});
        x_q    <= x_i;
        byp_q  <= byp_i;
      end
    end
  end

  always_comb begin
    rnd = {prod_q[PW-1], prod_q} + HALF;
    shr = rnd >>> FRAC;
    if (shr > MAXV)      sat_val = MAXV[DATA_W-1:0];
    else if (shr < MINV) sat_val = MINV[DATA_W-1:0];
    else                 sat_val = shr[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    y_q <= '0;
    else if (vld_q) y_q <= byp_q ? x_q : sat_val;
  end

  assign y_o = y_q;

  assert_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && byp_i) |=> ##1 (y_o == $past(x_i, 2)));
  assert_unity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !byp_i && coef_i == ONE) |=> ##1 (y_o == $past(x_i, 2)));
  assert_zero_coef_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !byp_i && coef_i == '0) |=> ##1 (y_o == '0));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !byp_i && coef_i <= ONE) |=> ##1 ((y_o >= 0) == ($past(x_i, 2) >= 0) || y_o == 0));
endmodule

// File: rtl/win4_apply.sv
module win4_apply #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int NPTS   = 64,
  localparam int IDX_W = $clog2(NPTS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic                    bypass_i,
  input  logic [LANES*DATA_W-1:0] re_i,
  input  logic [LANES*DATA_W-1:0] im_i,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_addr_i,
  input  logic [COEF_W-1:0]       wr_data_i,
  output logic                    valid_o,
  output logic [LANES*DATA_W-1:0] re_o,
  output logic [LANES*DATA_W-1:0] im_o
);
  logic                    s1_vld, s1_byp, s2_vld, out_vld;
  logic [LANES*DATA_W-1:0] s1_re, s1_im;
  logic [COEF_W-1:0]       coef;

  win_coef_table #(.NPTS(NPTS), .COEF_W(COEF_W)) u_tab (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i(valid_i), .rd_idx_i(idx_i),
    .coef_o(coef)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_byp  <= 1'b0;
      s1_re   <= '0;
      s1_im   <= '0;
      s2_vld  <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      s1_vld  <= valid_i;
      s2_vld  <= s1_vld;
      out_vld <= s2_vld;
      if (valid_i) begin
        s1_byp <= bypass_i;
        s1_re  <= re_i;
        s1_im  <= im_i;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [DATA_W-1:0] y_re, y_im;

    win_scale #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_re (
      .clk_i, .rst_ni, .vld_i(s1_vld), .byp_i(s1_byp), .coef_i(coef),
      .x_i(s1_re[k*DATA_W +: DATA_W]), .y_o(y_re)
    );
    win_scale #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_im (
      .clk_i, .rst_ni, .vld_i(s1_vld), .byp_i(s1_byp), .coef_i(coef),
      .x_i(s1_im[k*DATA_W +: DATA_W]), .y_o(y_im)
    );

    assign re_o[k*DATA_W +: DATA_W] = y_re;
    assign im_o[k*DATA_W +: DATA_W] = y_im;
  end

  assign valid_o = out_vld;

  assert_valid_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##2 valid_o);
  assert_idle_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##2 !valid_o);
  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> (!valid_o || $past(s2_vld)));
endmodule

// File: tb/tb_win4_apply.sv
module tb_win4_apply;
  localparam int LANES = 4, DW = 16, CW = 16, NP = 64, IW = 6;
  localparam real PI_V = 3.14159265358979323846;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, byp = 1'b0, we = 1'b0;
  logic [IW-1:0] idx = '0, waddr = '0;
  logic [CW-1:0] wdata = '0;
  logic [LANES*DW-1:0] re_in = '0, im_in = '0;
  logic valid_o;
  logic [LANES*DW-1:0] re_o, im_o;

  always #5 clk = ~clk;

  win4_apply dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .idx_i(idx), .bypass_i(byp),
    .re_i(re_in), .im_i(im_in), .wr_en_i(we), .wr_addr_i(waddr), .wr_data_i(wdata),
    .valid_o(valid_o), .re_o(re_o), .im_o(im_o)
  );

  int n_tests = 0, n_fail = 0;
  int sh[NP], ac[NP];
  bit pv[3];
  int pre[3][LANES], pim[3][LANES];
  string ptag[3];
  int xr[LANES], xi[LANES];

  function automatic int hann_ref(int n);
    real w;
    w = 0.5 - 0.5 * $cos(2.0 * PI_V * real'(n) / real'(NP));
    return int'($floor(w * 32768.0 + 0.5));
  endfunction

  function automatic int scale_ref(int x, int c);
    longint p, r;
    p = longint'(x) * longint'(c);
    r = (p + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: check the beat that left 3 edges ago, then drive a new one
  task automatic step(bit v, int ix, bit b, bit w_en, int w_a, int w_d, string tag);
    int c;
    @(negedge clk);
    chk({ptag[2], " valid_o"}, int'(valid_o), int'(pv[2]));
    if (pv[2]) begin
      for (int k = 0; k < LANES; k++) begin
        chk({ptag[2], " re"}, int'($signed(re_o[k*DW +: DW])), pre[2][k]);
        chk({ptag[2], " im"}, int'($signed(im_o[k*DW +: DW])), pim[2][k]);
      end
    end
    for (int s = 2; s > 0; s--) begin
      pv[s] = pv[s-1]; ptag[s] = ptag[s-1];
      for (int k = 0; k < LANES; k++) begin pre[s][k] = pre[s-1][k]; pim[s][k] = pim[s-1][k]; end
    end
    valid = v; idx = IW'(ix); byp = b; we = w_en; waddr = IW'(w_a); wdata = CW'(w_d);
    for (int k = 0; k < LANES; k++) begin
      re_in[k*DW +: DW] = DW'(xr[k]);
      im_in[k*DW +: DW] = DW'(xi[k]);
    end
    pv[0] = v; ptag[0] = tag;
    if (v) begin
      if (ix == 0) for (int i = 0; i < NP; i++) ac[i] = sh[i];
      c = ac[ix];
      for (int k = 0; k < LANES; k++) begin
        pre[0][k] = b ? xr[k] : scale_ref(xr[k], c);
        pim[0][k] = b ? xi[k] : scale_ref(xi[k], c);
      end
    end
    if (w_en) sh[w_a] = w_d;
  endtask

  task automatic rnd_data();
    for (int k = 0; k < LANES; k++) begin
      xr[k] = int'($urandom_range(0, 65535)) - 32768;
      xi[k] = int'($urandom_range(0, 65535)) - 32768;
    end
  endtask

  task automatic set_all(int v);
    for (int k = 0; k < LANES; k++) begin xr[k] = v + k; xi[k] = -v - 2*k; end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin sh[i] = hann_ref(i); ac[i] = sh[i]; end
    for (int s = 0; s < 3; s++) begin pv[s] = 1'b0; ptag[s] = "R4 idle"; end
    for (int k = 0; k < LANES; k++) begin xr[k] = 0; xi[k] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset valid_o", int'(valid_o), 0);
    chk("R1 reset re_o", int'(re_o != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset valid_o", int'(valid_o), 0);
    chk("R1 post-reset im_o", int'(im_o != '0), 0);

    // R2/R8: default Hann, random distinct per lane and component
    for (int i = 0; i < NP; i++) begin rnd_data(); step(1, i, 0, 0, 0, 0, "R2_R8 hann"); end
    // R3: full bypass block
    for (int i = 0; i < NP; i++) begin rnd_data(); step(1, i, 1, 0, 0, 0, "R3 bypass"); end
    // R9/R4: alternating bypass with idle gaps
    for (int i = 0; i < NP; i++) begin
      rnd_data();
      if (i % 5 == 4) step(0, i, 0, 0, 0, 0, "R4 gap");
      step(1, i, i[0], 0, 0, 0, "R9_R4 mixed");
    end
    // R5: writes mid-block stay staged until next boundary
    for (int i = 0; i < NP; i++) begin
      rnd_data();
      if (i == 10) step(1, i, 0, 1, 20, 16'h2000, "R5 write a");
      else if (i == 11) step(1, i, 0, 1, 40, 16'h7000, "R5 write b");
      else step(1, i, 0, 0, 0, 0, "R5 old table");
    end
    for (int i = 0; i < NP; i++) begin
      rnd_data();
      if (i == 0) step(1, 0, 0, 1, 21, 16'h1234, "R5 boundary write");
      else step(1, i, 0, 0, 0, 0, "R5 new table");
    end
    // R10: idle beat at index 0 must not commit
    rnd_data(); step(1, 5, 0, 1, 30, 16'h0100, "R10 stage");
    rnd_data(); step(0, 0, 0, 0, 0, 0, "R10 idle idx0");
    for (int i = 28; i < 33; i++) begin rnd_data(); step(1, i, 0, 0, 0, 0, "R10 no commit"); end
    rnd_data(); step(1, 0, 0, 1, 1, 16'hFFFF, "R10 commit");
    for (int i = 20; i < 32; i++) begin rnd_data(); step(1, i, 0, 1, 2, 16'h4000, "R5_R10 applied"); end
    // R6: saturation with coefficient near 2.0
    rnd_data(); step(1, 0, 0, 0, 0, 0, "R6 boundary");
    set_all(32000); step(1, 1, 0, 0, 0, 0, "R6 sat");
    for (int k = 0; k < LANES; k++) begin xr[k] = 32767; xi[k] = -32768; end
    step(1, 1, 0, 0, 0, 0, "R6 sat extreme");
    for (int k = 0; k < LANES; k++) begin xr[k] = 100 + k; xi[k] = -100 - k; end
    step(1, 1, 0, 0, 0, 0, "R6 in range");
    // R7: exact halves with coefficient 0.5
    xr[0] = 1; xr[1] = -1; xr[2] = 3; xr[3] = -3;
    xi[0] = 5; xi[1] = -5; xi[2] = 0; xi[3] = -32768;
    step(1, 2, 0, 0, 0, 0, "R7 round half");
    chk("R7 ref x=-3", scale_ref(-3, 16'h4000), -1);
    chk("R7 ref x=3", scale_ref(3, 16'h4000), 2);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R4 drain");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule